// File: doc/BRIEF.md
# Reconfiguration Context Scheduler

This block arbitrates a single reconfigurable region shared by several function modules. Each module owns a slice of the address space. A bus request addressed to a module is captured into a hold slot belonging to that module. The scheduler then decides whether the module must first be configured into the region. If the region is free, a load starts at once. If another module is running or a load is in flight, the module is parked in a first-in first-out wait queue. The held request is handed to the module only once the module is resident.

Load time is modelled by a counter. Its length comes from the configuration image size, the configuration port width, the ratio of core clocks to configuration clocks, and a fixed extra overhead. A design-time table maps prefetch hint events to modules, so a module can be configured before its first request arrives. Because the region holds one context at a time, starting a load evicts whatever idle module is resident, and the block reports that eviction.

Top module: `rcfg_ctx_sched`

## Requirements
- R1: After reset every module is in state code 0 (not loaded), `req_ready_o` is high, and `disp_valid_o`, `loading_o`, `flush_evt_o` and `q_ovf_o` are all low. The state of module i is on `mod_state_o[3i+2:3i]`, coded as follows: 0 not loaded, 1 waiting in queue, 2 loading, 3 loaded idle, 4 running.
- R2: The target module of a request is the value of the top log2(NUM_MODS) bits of `req_addr_i`. A dispatch is a one-cycle `disp_valid_o` pulse. It carries a one-hot `disp_sel_o` naming the target, together with the address and data of the held request.
- R3: An accepted request is held until its target module is loaded; no dispatch to a module happens before that. While a request to a module is held, `req_ready_o` is low for addresses in that module's range.
- R4: When the region is free, a request to a not-loaded module starts its load in the next cycle. A load keeps the module in state 2 for exactly ceil(CFG_BITS/PORT_W)*CFG_CLK_DIV+EXTRA_CYC cycles. The module then enters state 3.
- R5: A held request to a loaded idle module is dispatched and moves the module to running. A done pulse returns a running module to idle. A done pulse to a module that is not running has no effect.
- R6: A request to a not-loaded module while the region is busy moves the module to waiting and enqueues it.
- R7: Queued modules are loaded in arrival order. A queued load starts only when no module is running and no load is active.
- R8: A running module stays running until its own done pulse; no load preempts it.
- R9: At most one module is loading, idle or running at any time. Starting a load moves the resident idle module to not loaded and pulses its one-hot bit on `flush_evt_o` for one cycle.
- R10: A prefetch hint event e selects module PF_MAP[e] if bit e of PF_EN is set. The hint starts a load only when the region is free, the queue is empty, no held request is waiting on a not-loaded module, and the selected module is not loaded. Otherwise the hint is ignored.
- R11: When a module would be enqueued into a full queue, `q_ovf_o` is set and remains set until reset. The module stays not loaded with its request held, and it is enqueued once space frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Bus request valid |
| req_addr_i | input | ADDR_W | Request address; top bits select the module |
| req_data_i | input | DATA_W | Request payload |
| req_ready_o | output | 1 | Request accepted when high with valid |
| disp_valid_o | output | 1 | Dispatch pulse toward the modules |
| disp_sel_o | output | NUM_MODS | One-hot dispatch target |
| disp_addr_o | output | ADDR_W | Address of the dispatched request |
| disp_data_o | output | DATA_W | Payload of the dispatched request |
| done_i | input | NUM_MODS | Per-module completion pulse |
| pf_valid_i | input | 1 | Prefetch hint valid |
| pf_evt_i | input | EVT_W | Prefetch hint event number |
| mod_state_o | output | 3*NUM_MODS | Per-module lifecycle state codes |
| loading_o | output | 1 | A configuration load is in progress |
| resident_o | output | NUM_MODS | Module is idle or running in the region |
| flush_evt_o | output | NUM_MODS | One-cycle eviction pulse, one-hot |
| q_ovf_o | output | 1 | Sticky wait-queue overflow flag |

## Verification
The bench builds the block with four modules and 12-bit addresses. The configuration image is 64 bits on a 16-bit port, with two core clocks per configuration clock and three cycles of overhead, so each load lasts 11 cycles. Because the load is short, the bench can count the exact load length and can chain several queued loads while checking their order. The queue depth is set to two, so three blocked modules are enough to drive the overflow path and the retry that follows it. The prefetch table maps each event to a neighbouring module, and one event is left disabled so that the enable mask can be shown to work.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

  typedef enum logic [2:0] {
    MS_OFF  = 3'd0,
    MS_WAIT = 3'd1,
    MS_LOAD = 3'd2,
    MS_IDLE = 3'd3,
    MS_RUN  = 3'd4
  } mod_st_e;

  // cycles a load occupies: image words times clock ratio plus overhead
  function automatic int unsigned load_cycles(input int unsigned bits,
                                              input int unsigned port_w,
                                              input int unsigned div,
                                              input int unsigned extra);
    return ((bits + port_w - 1) / port_w) * div + extra;
  endfunction

  // index of the lowest set bit, zero when none
  function automatic int unsigned first_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/rcfg_load_timer.sv
module rcfg_load_timer #(
  parameter int unsigned LOAD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(LOAD_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(LOAD_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign expire_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/rcfg_wait_fifo.sv
module rcfg_wait_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) begin
        mem_q[wptr_q] <= din_i;
        wptr_q        <= nxt(wptr_q);
      end
      if (pop_i) rptr_q <= nxt(rptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign dout_o  = mem_q[rptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/rcfg_req_hold.sv
module rcfg_req_hold #(
  parameter int unsigned NUM_MODS = 4,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [DATA_W-1:0]          req_data_i,
  output logic                       req_ready_o,
  input  logic [NUM_MODS-1:0]        clr_i,
  output logic [NUM_MODS-1:0]        hold_v_o,
  output logic [NUM_MODS*ADDR_W-1:0] slot_addr_o,
  output logic [NUM_MODS*DATA_W-1:0] slot_data_o
);
  localparam int unsigned IDX_W = $clog2(NUM_MODS);

  logic [IDX_W-1:0]    tgt;
  logic [NUM_MODS-1:0] hold_q;

  assign tgt         = req_addr_i[ADDR_W-1 -: IDX_W];
  assign req_ready_o = !hold_q[tgt];
  assign hold_v_o    = hold_q;

  for (genvar g = 0; g < NUM_MODS; g++) begin : g_slot
    logic take;
    assign take = req_valid_i && req_ready_o && (tgt == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_q[g] <= 1'b0;
      end else if (take) begin
        hold_q[g]                          <= 1'b1;
        slot_addr_o[g*ADDR_W +: ADDR_W]    <= req_addr_i;
        slot_data_o[g*DATA_W +: DATA_W]    <= req_data_i;
      end else if (clr_i[g]) begin
        hold_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rcfg_ctx_sched.sv
module rcfg_ctx_sched #(
  parameter int unsigned NUM_MODS    = 4,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CFG_BITS    = 4096,
  parameter int unsigned PORT_W      = 16,
  parameter int unsigned CFG_CLK_DIV = 2,
  parameter int unsigned EXTRA_CYC   = 8,
  parameter int unsigned Q_DEPTH     = 4,
  parameter int unsigned NUM_EVT     = 4,
  parameter logic [NUM_EVT*$clog2(NUM_MODS)-1:0] PF_MAP = 8'b00_11_10_01,
  parameter logic [NUM_EVT-1:0] PF_EN = '1,
  localparam int unsigned EVT_W = $clog2(NUM_EVT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_data_i,
  output logic                  req_ready_o,
  output logic                  disp_valid_o,
  output logic [NUM_MODS-1:0]   disp_sel_o,
  output logic [ADDR_W-1:0]     disp_addr_o,
  output logic [DATA_W-1:0]     disp_data_o,
  input  logic [NUM_MODS-1:0]   done_i,
  input  logic                  pf_valid_i,
  input  logic [EVT_W-1:0]      pf_evt_i,
  output logic [3*NUM_MODS-1:0] mod_state_o,
  output logic                  loading_o,
  output logic [NUM_MODS-1:0]   resident_o,
  output logic [NUM_MODS-1:0]   flush_evt_o,
  output logic                  q_ovf_o
);
  import rcfg_pkg::*;

  localparam int unsigned IDX_W    = $clog2(NUM_MODS);
  localparam int unsigned LOAD_CYC = load_cycles(CFG_BITS, PORT_W, CFG_CLK_DIV, EXTRA_CYC);

  mod_st_e st_q [NUM_MODS];
  mod_st_e st_d [NUM_MODS];

  logic [NUM_MODS-1:0] is_off, is_idle, is_run;
  logic [NUM_MODS-1:0] hold_v, disp_vec, pend_vec, clr_vec;
  logic [NUM_MODS*ADDR_W-1:0] slot_addr;
  logic [NUM_MODS*DATA_W-1:0] slot_data;

  logic             disp_any, pend_any, free, start, pop, push, ovf_set;
  logic             q_empty, q_full, q_room, pf_ok;
  logic             ld_busy, ld_expire;
  logic [IDX_W-1:0] disp_idx, pend_idx, start_idx, q_head, pf_mod, ld_idx_q;

  rcfg_req_hold #(.NUM_MODS(NUM_MODS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_data_i(req_data_i),
    .req_ready_o(req_ready_o), .clr_i(clr_vec), .hold_v_o(hold_v),
    .slot_addr_o(slot_addr), .slot_data_o(slot_data)
  );

  rcfg_wait_fifo #(.DEPTH(Q_DEPTH), .W(IDX_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push_i(push), .din_i(pend_idx), .pop_i(pop),
    .dout_o(q_head), .empty_o(q_empty), .full_o(q_full)
  );

  rcfg_load_timer #(.LOAD_CYC(LOAD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(ld_busy), .expire_o(ld_expire)
  );

  // state classification
  always_comb begin
    for (int i = 0; i < NUM_MODS; i++) begin
      is_off[i]  = (st_q[i] == MS_OFF);
      is_idle[i] = (st_q[i] == MS_IDLE);
      is_run[i]  = (st_q[i] == MS_RUN);
      mod_state_o[3*i +: 3] = st_q[i];
    end
  end

  // scheduling decision for this cycle
  always_comb begin
    disp_vec = hold_v & is_idle;
    disp_any = |disp_vec;
    disp_idx = IDX_W'(first_set(32'(disp_vec)));
    pend_vec = hold_v & is_off;
    pend_any = |pend_vec;
    pend_idx = IDX_W'(first_set(32'(pend_vec)));
    free     = !(|is_run) && !ld_busy && !disp_any;
    pf_mod   = PF_MAP[pf_evt_i*IDX_W +: IDX_W];
    pf_ok    = pf_valid_i && PF_EN[pf_evt_i] && is_off[pf_mod];

    start = 1'b0; pop = 1'b0; push = 1'b0; ovf_set = 1'b0;
    start_idx = '0;
    if (free) begin
      if (!q_empty) begin
        start = 1'b1; pop = 1'b1; start_idx = q_head;
      end else if (pend_any) begin
        start = 1'b1; start_idx = pend_idx;
      end else if (pf_ok) begin
        start = 1'b1; start_idx = pf_mod;
      end
    end
    q_room = !q_full || pop;
    if (pend_any && !(free && q_empty)) begin
      if (q_room) push    = 1'b1;
      else        ovf_set = 1'b1;
    end
    clr_vec = disp_any ? (NUM_MODS'(1) << disp_idx) : '0;
  end

  always_comb begin
    for (int i = 0; i < NUM_MODS; i++) begin
      st_d[i] = st_q[i];
      if (is_run[i] && done_i[i])                    st_d[i] = MS_IDLE;
      if (disp_any && disp_idx == IDX_W'(i))         st_d[i] = MS_RUN;
      if (start && is_idle[i])                       st_d[i] = MS_OFF;
      if (start && start_idx == IDX_W'(i))           st_d[i] = MS_LOAD;
      if (push && pend_idx == IDX_W'(i))             st_d[i] = MS_WAIT;
      if (ld_expire && ld_idx_q == IDX_W'(i))        st_d[i] = MS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MODS; i++) st_q[i] <= MS_OFF;
      ld_idx_q     <= '0;
      disp_valid_o <= 1'b0;
      disp_sel_o   <= '0;
      disp_addr_o  <= '0;
      disp_data_o  <= '0;
      flush_evt_o  <= '0;
      q_ovf_o      <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_MODS; i++) st_q[i] <= st_d[i];
      if (start) ld_idx_q <= start_idx;
      disp_valid_o <= disp_any;
      disp_sel_o   <= clr_vec;
      if (disp_any) begin
        disp_addr_o <= slot_addr[disp_idx*ADDR_W +: ADDR_W];
        disp_data_o <= slot_data[disp_idx*DATA_W +: DATA_W];
      end
      flush_evt_o <= start ? is_idle : '0;
      if (ovf_set) q_ovf_o <= 1'b1;
    end
  end

  assign loading_o  = ld_busy;
  assign resident_o = is_idle | is_run;
endmodule

// File: rtl/rcfg_sched_chk.sv
module rcfg_sched_chk #(
  parameter int unsigned NUM_MODS = 4,
  parameter int unsigned LOAD_CYC = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [3*NUM_MODS-1:0] mod_state,
  input logic                  disp_valid,
  input logic [NUM_MODS-1:0]   disp_sel,
  input logic [NUM_MODS-1:0]   done,
  input logic                  loading,
  input logic [NUM_MODS-1:0]   flush_evt,
  input logic                  q_ovf
);
  logic [NUM_MODS-1:0] off_v, ld_v, idle_v, run_v;
  logic [31:0]         ld_len;

  always_comb begin
    for (int i = 0; i < NUM_MODS; i++) begin
      off_v[i]  = (mod_state[3*i +: 3] == 3'd0);
      ld_v[i]   = (mod_state[3*i +: 3] == 3'd2);
      idle_v[i] = (mod_state[3*i +: 3] == 3'd3);
      run_v[i]  = (mod_state[3*i +: 3] == 3'd4);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ld_len <= '0;
    else if (loading) ld_len <= ld_len + 1;
    else              ld_len <= '0;
  end

  // R9
  ctx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ld_v | idle_v | run_v) <= 1);
  // R2
  disp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> $countones(disp_sel) == 1);
  // R3
  disp_resident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_sel & run_v) != '0);
  // R8
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_v) & ~$past(done) & ~run_v) == '0);
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_ovf |=> q_ovf);
  // R9
  flush_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_evt != '0) |-> ($countones(flush_evt) == 1 && (flush_evt & ~off_v) == '0));
  // R4
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loading) |-> ld_len == 32'(LOAD_CYC));
  // R4
  loading_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loading == (ld_v != '0));
endmodule

bind rcfg_ctx_sched rcfg_sched_chk #(.NUM_MODS(NUM_MODS), .LOAD_CYC(LOAD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mod_state(mod_state_o), .disp_valid(disp_valid_o),
  .disp_sel(disp_sel_o), .done(done_i), .loading(loading_o),
  .flush_evt(flush_evt_o), .q_ovf(q_ovf_o)
);

// File: tb/rcfg_ctx_sched_tb.sv
module rcfg_ctx_sched_tb;
  localparam int CLK_P = 10;
  localparam int NM    = 4;
  localparam int AW    = 12;
  localparam int DW    = 16;
  localparam int EXP_LOAD = ((64 + 15) / 16) * 2 + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, disp_valid, loading, q_ovf;
  logic [NM-1:0] disp_sel, resident, flush_evt;
  logic [NM-1:0] done = '0;
  logic [AW-1:0] disp_addr;
  logic [DW-1:0] disp_data;
  logic pf_valid = 1'b0;
  logic [1:0] pf_evt = '0;
  logic [3*NM-1:0] mod_state;

  int n_chk = 0, n_fail = 0;
  bit saw_load;

  always #(CLK_P/2) clk = ~clk;

  rcfg_ctx_sched #(.NUM_MODS(NM), .ADDR_W(AW), .DATA_W(DW), .CFG_BITS(64), .PORT_W(16),
    .CFG_CLK_DIV(2), .EXTRA_CYC(3), .Q_DEPTH(2), .NUM_EVT(4),
    .PF_MAP(8'b00_11_10_01), .PF_EN(4'b0111)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_data_i(req_data), .req_ready_o(req_ready), .disp_valid_o(disp_valid),
    .disp_sel_o(disp_sel), .disp_addr_o(disp_addr), .disp_data_o(disp_data),
    .done_i(done), .pf_valid_i(pf_valid), .pf_evt_i(pf_evt), .mod_state_o(mod_state),
    .loading_o(loading), .resident_o(resident), .flush_evt_o(flush_evt), .q_ovf_o(q_ovf));

  function automatic logic [2:0] st(input int i);
    return mod_state[3*i +: 3];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_req(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); req_valid = 1'b1; req_addr = a; req_data = d;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic pulse_done(input int i);
    @(negedge clk); done[i] = 1'b1;
    @(negedge clk); done = '0;
  endtask

  task automatic send_pf(input logic [1:0] e);
    @(negedge clk); pf_valid = 1'b1; pf_evt = e;
    @(negedge clk); pf_valid = 1'b0;
  endtask

  task automatic wait_disp(input string tag, input logic [NM-1:0] exp_sel);
    bit got = 0;
    saw_load = 0;
    for (int k = 0; k < 60 && !got; k++) begin
      if (loading) saw_load = 1;
      if (disp_valid) begin
        got = 1;
        chk({tag, " dispatch target"}, 32'(disp_sel), 32'(exp_sel));
      end else @(negedge clk);
    end
    if (!got) chk({tag, " dispatch seen"}, 0, 1);
  endtask

  task automatic t_reset;
    chk("R1 states off", 32'(mod_state), 0);
    chk("R1 ready", 32'(req_ready), 1);
    chk("R1 outputs idle", {28'd0, disp_valid, loading, |flush_evt, q_ovf}, 0);
  endtask

  task automatic t_cold_load;
    int n_ld = 0;
    bit early = 0;
    send_req(12'h4A5, 16'hBEEF);
    req_addr = 12'h7F0;
    #1 chk("R3 ready low while held", 32'(req_ready), 0);
    chk("R4 not yet loading", 32'(st(1)), 0);
    @(negedge clk);
    while (st(1) == 3'd2 && n_ld < 100) begin
      n_ld++;
      if (disp_valid) early = 1;
      @(negedge clk);
    end
    chk("R4 load length", 32'(n_ld), 32'(EXP_LOAD));
    chk("R3 no dispatch before loaded", 32'(early), 0);
    wait_disp("R2", 4'b0010);
    chk("R2 dispatch addr", 32'(disp_addr), 32'h4A5);
    chk("R2 dispatch data", 32'(disp_data), 32'hBEEF);
    chk("R5 running", 32'(st(1)), 4);
  endtask

  task automatic t_done;
    pulse_done(1);
    chk("R5 done to idle", 32'(st(1)), 3);
    pulse_done(2);
    chk("R5 done ignored when not running", 32'(st(2)), 0);
    send_req(12'h401, 16'h1111);
    wait_disp("R5 resident", 4'b0010);
    chk("R5 no reload for resident", 32'(saw_load), 0);
    pulse_done(1);
  endtask

  task automatic t_flush;
    int n_fl = 0;
    logic [NM-1:0] fl_seen = '0;
    send_req(12'h800, 16'h2222);
    for (int k = 0; k < 6; k++) begin
      if (flush_evt != '0) begin n_fl++; fl_seen = flush_evt; end
      @(negedge clk);
    end
    chk("R9 flush pulse cycles", 32'(n_fl), 1);
    chk("R9 flush target", 32'(fl_seen), 32'b0010);
    chk("R9 evicted off", 32'(st(1)), 0);
    wait_disp("R9 new module", 4'b0100);
    pulse_done(2);
  endtask

  task automatic t_queue;
    send_req(12'h010, 16'h0A0A);
    wait_disp("R6 first", 4'b0001);
    send_req(12'h400, 16'h0001);
    send_req(12'hC00, 16'h0003);
    send_req(12'h800, 16'h0002);
    @(negedge clk); @(negedge clk);
    chk("R6 module1 waiting", 32'(st(1)), 1);
    chk("R6 module3 waiting", 32'(st(3)), 1);
    chk("R11 blocked stays off", 32'(st(2)), 0);
    chk("R11 overflow set", 32'(q_ovf), 1);
    req_addr = 12'h8F0;
    #1 chk("R3 ready low for held module2", 32'(req_ready), 0);
    repeat (20) @(negedge clk);
    chk("R8 still running", 32'(st(0)), 4);
    chk("R7 no load while running", 32'(loading), 0);
    pulse_done(0);
    wait_disp("R7 order first", 4'b0010);
    chk("R7 module3 still queued", 32'(st(3)), 1);
    chk("R11 retried into queue", 32'(st(2)), 1);
    pulse_done(1);
    wait_disp("R7 order second", 4'b1000);
    pulse_done(3);
    wait_disp("R7 order third", 4'b0100);
    pulse_done(2);
    chk("R11 overflow sticky", 32'(q_ovf), 1);
  endtask

  task automatic t_prefetch;
    bit any_disp = 0;
    send_pf(2'd0);
    chk("R10 hint starts load", 32'(st(1)), 2);
    chk("R10 loading flag", 32'(loading), 1);
    for (int k = 0; k < EXP_LOAD + 3; k++) begin
      if (disp_valid) any_disp = 1;
      @(negedge clk);
    end
    chk("R10 prefetched idle", 32'(st(1)), 3);
    chk("R10 no dispatch without request", 32'(any_disp), 0);
    send_req(12'h420, 16'h3333);
    wait_disp("R10 after prefetch", 4'b0010);
    chk("R10 no second load", 32'(saw_load), 0);
    send_pf(2'd1);
    chk("R10 hint ignored while running", 32'(st(2)), 0);
    chk("R10 no load while running", 32'(loading), 0);
    pulse_done(1);
    send_pf(2'd3);
    chk("R10 disabled entry ignored", 32'(st(0)), 0);
    chk("R10 disabled no load", 32'(loading), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_load();
    t_done();
    t_flush();
    t_queue();
    t_prefetch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule